// File: doc/BRIEF.md
# Two-Stage Cascaded Watchdog Timer

The block guards against software runaway. It chains two 8-bit down-counters: a low stage and a high stage. When the high stage counts past zero, the block raises a one-cycle internal reset. After reset the timer stays idle and keeps its counts. The first write of any value to its control register starts it. Every later write reloads both stages to 0xFF. Software therefore services the timer by writing the register often enough.

The low stage steps on a prescaled tick. That tick is either the main-clock divide-by-8 strobe or the sub-clock divide-by-16 strobe, and an input picks which one. Control bit 7 sets what clocks the high stage. When it is clear, the high stage steps on each wrap of the low stage, which gives the long timeout. When it is set, the high stage steps on the same prescaled tick, which gives a timeout 256 times shorter. Control bit 6 can only be set by software. Once it is set, a stop request becomes an internal reset. A register read returns both control bits together with the upper six bits of the high stage.

Top module: `wdt_cascade`

## Requirements
- R1: After reset, `reg_rdata_o` reads 0x3F and `wdt_rst_o` is 0. Until the first register write, the counters hold their values whatever ticks arrive.
- R2: Any register write loads both stages with 0xFF and starts counting. The readback becomes {bit7, bit6, 6'h3F}.
- R3: While running, the low stage decrements once for each selected tick. `clk_sel_i`=0 selects `main_tick_i` and `clk_sel_i`=1 selects `sub_tick_i`. The tick that is not selected has no effect.
- R4: With control bit 7 at 0, the high stage decrements once each time the low stage wraps from 0x00 to 0xFF. With one tick per cycle, the reset pulse follows the 65536th tick after a write.
- R5: With control bit 7 at 1, the high stage decrements once for each selected tick.
- R6: When the high stage steps while it is at 0x00, `wdt_rst_o` is 1 for exactly one cycle, starting on the next clock edge.
- R7: Control bit 6 is set by writing a 1 to bit 6. Writing a 0 to bit 6 does not clear it. Only a reset pulse or `rst_ni` clears it.
- R8: A `stop_req_i` while bit 6 is 1 produces a reset pulse, and it does so even if a register write happens in the same cycle. A `stop_req_i` while bit 6 is 0 has no effect.
- R9: `reg_rdata_o` bit 7 is the high-stage source select, bit 6 is the stop-disable bit, and bits 5..0 are high-stage bits 7..2.
- R10: A reset pulse returns the block to its post-reset state: stopped, both stages at 0xFF, and both control bits at 0.
- R11: A register write in the same cycle as a decrement or a high-stage underflow wins. The counters reload and no reset pulse follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| main_tick_i | input | 1 | One-cycle strobe at main clock / 8 |
| sub_tick_i | input | 1 | One-cycle strobe at sub clock / 16 |
| clk_sel_i | input | 1 | Tick select: 0 main, 1 sub |
| reg_we_i | input | 1 | Control register write strobe |
| reg_wdata_i | input | 8 | Write data (bit 7 source select, bit 6 stop disable) |
| reg_rdata_o | output | 8 | Readback {source select, stop disable, high[7:2]} |
| stop_req_i | input | 1 | Stop-instruction request strobe |
| wdt_rst_o | output | 1 | One-cycle internal reset pulse |

## Verification
The assertions assume that the tick inputs are single-cycle strobes synchronous to `clk_i`. They also assume that `clk_sel_i` changes only between ticks, so that each cycle has one well-defined step source. The stimulus meets these assumptions by driving every input on the falling edge and changing the selection only in cycles with no tick. It also brings a register write and a stop request into the same cycle as a tick or an underflow, so that the priority rules are exercised under legal inputs.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int unsigned WDT_CNT_W = 8;
  localparam int unsigned WDT_REG_W = 8;

  typedef struct packed {
    logic src_tick;  // high stage steps on prescaled tick
    logic stop_dis;  // stop request becomes reset
  } wdt_ctrl_t;
endpackage

// File: rtl/wdt_tick_sel.sv
module wdt_tick_sel #(
  parameter int unsigned N_SRC = 2,
  localparam int unsigned SEL_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic [N_SRC-1:0] src_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             tick_o
);
  logic [N_SRC-1:0] hit;

  for (genvar g = 0; g < N_SRC; g++) begin : g_src
    assign hit[g] = src_i[g] && (sel_i == SEL_W'(g));
  end

  assign tick_o = |hit;
endmodule

// File: rtl/wdt_down_stage.sv
module wdt_down_stage #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         load_i,
  input  logic         step_i,
  output logic [W-1:0] cnt_o,
  output logic         uf_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '1;
    else if (clr_i || load_i) cnt_q <= '1;
    else if (step_i)          cnt_q <= cnt_q - 1'b1;
  end

  // wrap strobe, suppressed by a reload
  assign uf_o  = step_i && !load_i && (cnt_q == '0);
  assign cnt_o = cnt_q;

  p_dec_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !load_i && !clr_i) |=> (cnt_q == $past(cnt_q) - 1'b1));

  p_reload_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i || clr_i) |=> (cnt_q == '1));

  p_idle_hold_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!step_i && !load_i && !clr_i) |=> $stable(cnt_q));
endmodule

// File: rtl/wdt_ctrl.sv
module wdt_ctrl
  import wdt_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      we_i,
  input  wdt_ctrl_t wr_ctrl_i,
  input  logic      hi_uf_i,
  input  logic      stop_req_i,
  output wdt_ctrl_t ctrl_o,
  output logic      run_o,
  output logic      fire_o,
  output logic      wdt_rst_o
);
  wdt_ctrl_t ctrl_q;
  logic      run_q;
  logic      rst_q;

  // stop trip is not maskable by a write; underflow already is
  assign fire_o = hi_uf_i || (stop_req_i && ctrl_q.stop_dis);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      run_q  <= 1'b0;
      rst_q  <= 1'b0;
    end else begin
      rst_q <= fire_o;
      if (fire_o) begin
        ctrl_q <= '0;
        run_q  <= 1'b0;
      end else if (we_i) begin
        run_q           <= 1'b1;
        ctrl_q.src_tick <= wr_ctrl_i.src_tick;
        ctrl_q.stop_dis <= ctrl_q.stop_dis | wr_ctrl_i.stop_dis;
      end
    end
  end

  assign ctrl_o    = ctrl_q;
  assign run_o     = run_q;
  assign wdt_rst_o = rst_q;

  p_pulse_width_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdt_rst_o |=> !wdt_rst_o);

  p_sticky_dis_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_q.stop_dis && !fire_o) |=> ctrl_q.stop_dis);

  p_stop_trip_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_req_i && ctrl_q.stop_dis) |=> wdt_rst_o);

  p_start_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !fire_o) |=> run_q);

  p_cleared_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdt_rst_o |-> (!run_q && ctrl_q == '0));
endmodule

// File: rtl/wdt_cascade.sv
module wdt_cascade
  import wdt_pkg::*;
#(
  parameter int unsigned CNT_W = WDT_CNT_W,
  parameter int unsigned REG_W = WDT_REG_W,
  localparam int unsigned RDBK_W = REG_W - 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             main_tick_i,
  input  logic             sub_tick_i,
  input  logic             clk_sel_i,
  input  logic             reg_we_i,
  input  logic [REG_W-1:0] reg_wdata_i,
  output logic [REG_W-1:0] reg_rdata_o,
  input  logic             stop_req_i,
  output logic             wdt_rst_o
);
  localparam int unsigned N_SRC = 2;

  wdt_ctrl_t  ctrl, wr_ctrl;
  logic       tick, run, fire;
  logic       lo_step, lo_uf, hi_step, hi_uf;
  logic [CNT_W-1:0] lo_cnt, hi_cnt;

  wdt_tick_sel #(.N_SRC(N_SRC)) u_tick_sel (
    .src_i  ({sub_tick_i, main_tick_i}),
    .sel_i  (clk_sel_i),
    .tick_o (tick)
  );

  assign lo_step = run && tick;

  wdt_down_stage #(.W(CNT_W)) u_lo (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (fire),
    .load_i (reg_we_i),
    .step_i (lo_step),
    .cnt_o  (lo_cnt),
    .uf_o   (lo_uf)
  );

  assign hi_step = ctrl.src_tick ? lo_step : lo_uf;

  wdt_down_stage #(.W(CNT_W)) u_hi (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (fire),
    .load_i (reg_we_i),
    .step_i (hi_step),
    .cnt_o  (hi_cnt),
    .uf_o   (hi_uf)
  );

  assign wr_ctrl.src_tick = reg_wdata_i[REG_W-1];
  assign wr_ctrl.stop_dis = reg_wdata_i[REG_W-2];

  wdt_ctrl u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (reg_we_i),
    .wr_ctrl_i  (wr_ctrl),
    .hi_uf_i    (hi_uf),
    .stop_req_i (stop_req_i),
    .ctrl_o     (ctrl),
    .run_o      (run),
    .fire_o     (fire),
    .wdt_rst_o  (wdt_rst_o)
  );

  assign reg_rdata_o = {ctrl.src_tick, ctrl.stop_dis, hi_cnt[CNT_W-1 -: RDBK_W]};

  logic unused_bits;
  assign unused_bits = ^{reg_wdata_i[RDBK_W-1:0], lo_cnt};

  p_stopped_hold_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run && !reg_we_i && !fire) |=> ($stable(hi_cnt) && $stable(lo_cnt)));

  p_hi_on_wrap_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run && !ctrl.src_tick && !lo_uf && !reg_we_i && !fire) |=> $stable(hi_cnt));

  p_hi_on_tick_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run && ctrl.src_tick && tick && !reg_we_i && !fire) |=> (hi_cnt != $past(hi_cnt)));

  p_write_wins_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && !stop_req_i) |=> (!wdt_rst_o && hi_cnt == '1 && lo_cnt == '1));

  p_uf_fires_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hi_uf |=> wdt_rst_o);
endmodule

// File: tb/wdt_cascade_tb_top.sv
module wdt_cascade_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WD_LIMIT   = 150000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       main_tick = 1'b0, sub_tick = 1'b0, clk_sel = 1'b0;
  logic       we = 1'b0, stop_req = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       wrst;

  int checks = 0, fails = 0, pulses = 0, cycles = 0;

  // reference model state
  int m_lo = 255, m_hi = 255;
  bit m_run = 0, m_sel = 0, m_dis = 0, m_rst = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wdt_cascade dut_i (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .main_tick_i (main_tick),
    .sub_tick_i  (sub_tick),
    .clk_sel_i   (clk_sel),
    .reg_we_i    (we),
    .reg_wdata_i (wdata),
    .reg_rdata_o (rdata),
    .stop_req_i  (stop_req),
    .wdt_rst_o   (wrst)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    bit t, lw, hs, hu, fire;
    cycles++;
    if (!rst_n) begin
      m_lo = 255; m_hi = 255; m_run = 0; m_sel = 0; m_dis = 0; m_rst = 0;
    end else begin
      t    = clk_sel ? sub_tick : main_tick;
      lw   = m_run && t && !we && m_lo == 0;
      hs   = m_run && !we && (m_sel ? t : lw);
      hu   = hs && m_hi == 0;
      fire = hu || (stop_req && m_dis);
      m_rst = fire;
      if (fire) begin
        m_lo = 255; m_hi = 255; m_run = 0; m_sel = 0; m_dis = 0;
      end else if (we) begin
        m_lo = 255; m_hi = 255; m_run = 1;
        m_sel = wdata[7]; m_dis = m_dis | wdata[6];
      end else if (m_run && t) begin
        m_lo = (m_lo + 255) % 256;
        if (hs) m_hi = (m_hi + 255) % 256;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk("R9 readback vs model", int'(rdata),
          (int'(m_sel) << 7) | (int'(m_dis) << 6) | (m_hi >> 2));
      chk("R6 reset pulse vs model", int'(wrst), int'(m_rst));
      if (wrst) pulses++;
    end
  end

  task automatic step(input bit mt, input bit st, input bit w,
                      input logic [7:0] wd, input bit sr);
    main_tick = mt; sub_tick = st; we = w; wdata = wd; stop_req = sr;
    @(negedge clk);
    #1;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    if (cycles > WD_LIMIT) begin
      checks++; fails++;
      $display("FAIL watchdog: actual %0d cycles expected below %0d", cycles, WD_LIMIT);
      finish_run();
    end
  end

  initial begin
    int p0;
    int n;
    repeat (3) @(negedge clk);
    #1 rst_n = 1'b1;
    chk("R1 reset readback", int'(rdata), 'h3F);
    chk("R1 reset pulse low", int'(wrst), 0);

    // R1: stopped until first write
    repeat (30) step(1, 1, 0, 8'h00, 0);
    chk("R1 idle readback", int'(rdata), 'h3F);
    chk("R1 idle no pulse", pulses, 0);

    // R2 start with short source; R3 unselected tick ignored
    clk_sel = 1'b1;
    step(0, 0, 1, 8'h80, 0);
    chk("R2 write reload", int'(rdata), 'hBF);
    repeat (40) step(1, 0, 0, 8'h00, 0);
    chk("R3 main tick ignored on sub", int'(rdata), 'hBF);
    repeat (8) step(0, 1, 0, 8'h00, 0);
    chk("R5 high steps per tick", int'(rdata), 'hBD);

    // R6 underflow boundary
    p0 = pulses;
    repeat (247) step(0, 1, 0, 8'h00, 0);
    chk("R6 high at zero", int'(rdata), 'h80);
    chk("R6 no pulse at zero", pulses, p0);
    step(0, 1, 0, 8'h00, 0);
    chk("R6 pulse on underflow", pulses, p0 + 1);
    chk("R10 state cleared", int'(rdata), 'h3F);
    repeat (20) step(1, 1, 0, 8'h00, 0);
    chk("R10 stopped after pulse", int'(rdata), 'h3F);
    chk("R6 single pulse", pulses, p0 + 1);

    // R11 write beats underflow
    step(0, 0, 1, 8'h80, 0);
    repeat (255) step(0, 1, 0, 8'h00, 0);
    chk("R11 high at zero", int'(rdata), 'h80);
    p0 = pulses;
    step(0, 1, 1, 8'h80, 0);
    chk("R11 write reloads", int'(rdata), 'hBF);
    step(0, 0, 0, 8'h00, 0);
    chk("R11 no pulse", pulses, p0);

    // R8 ignored without disable bit
    step(0, 0, 0, 8'h00, 1);
    step(0, 0, 0, 8'h00, 0);
    chk("R8 stop ignored", pulses, p0);
    chk("R8 stop ignored readback", int'(rdata), 'hBF);

    // R4 long cascade on main tick
    step(0, 0, 0, 8'h00, 0);
    clk_sel = 1'b0;
    step(0, 0, 1, 8'h00, 0);
    repeat (1023) step(1, 0, 0, 8'h00, 0);
    chk("R4 before fourth wrap", int'(rdata), 'h3F);
    step(1, 0, 0, 8'h00, 0);
    chk("R4 after fourth wrap", int'(rdata), 'h3E);
    p0 = pulses;
    n = 0;
    while (pulses == p0 && n < 70000) begin
      step(1, 0, 0, 8'h00, 0);
      n++;
    end
    chk("R4 ticks to timeout", n + 1024, 65536);

    // R7 sticky bit; R9 field placement
    step(0, 0, 1, 8'h40, 0);
    chk("R7 set disable", int'(rdata), 'h7F);
    step(0, 0, 1, 8'h00, 0);
    chk("R7 not cleared by write", int'(rdata), 'h7F);
    step(0, 0, 1, 8'hC0, 0);
    chk("R9 both control bits", int'(rdata), 'hFF);

    // R8 trip, then trip with simultaneous write
    p0 = pulses;
    step(0, 0, 0, 8'h00, 1);
    step(0, 0, 0, 8'h00, 0);
    chk("R8 stop trips reset", pulses, p0 + 1);
    chk("R8 cleared after trip", int'(rdata), 'h3F);
    step(0, 0, 1, 8'h40, 0);
    step(0, 0, 1, 8'h00, 1);
    step(0, 0, 0, 8'h00, 0);
    chk("R8 trip beats write", pulses, p0 + 2);
    chk("R8 cleared after trip with write", int'(rdata), 'h3F);

    // R9 mid-count readback
    clk_sel = 1'b1;
    step(0, 0, 1, 8'h80, 0);
    repeat (5) step(0, 1, 0, 8'h00, 0);
    chk("R9 mid count", int'(rdata), 'hBE);

    finish_run();
  end
endmodule